// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block watches a byte-wide flash data stream and computes Reed-Solomon parity over one sector of data bytes. The code works over GF(2^10) with the field polynomial x^10+x^3+1. Its generator has degree six, with roots alpha^0 through alpha^5. Every data byte is complemented and then enters the divider as one 10-bit symbol whose two upper bits are zero. A sector of blank (all 0xFF) bytes therefore yields zero parity.

The six parity symbols are packed into an 8-byte image, and software reads that image through two windows. The complemented window is the copy that is written to flash. The plain window gives each byte with its bit order reversed, for syndrome work in software.

The engine has two modes. In generate mode it stops after the sector. In check mode it then takes the eight stored parity bytes, compares them with its own complemented image, and latches a mismatch flag. Locating and correcting errors is left to software.

Control is a small FSM with four states:
- IDLE: frozen, bytes ignored.
- DATA: data bytes are accepted and the divider advances.
- STORED: check mode only; stored parity bytes are compared.
- DONE: the sector is complete and bytes are ignored.

Transitions:
- go_clear: a control write with clear and feed set moves to DATA.
- go_freeze: a control write with feed clear moves to IDLE.
- go_resume: a control write with feed set and clear zero returns to the phase that matches the byte count.
- data_end: the last data byte moves to DONE in generate mode and to STORED in check mode.
- check_end: the last stored byte moves to DONE.

Top module: `rs_page_ecc`

## Requirements
- R1: After reset, the control register reads 0x00 and the check register reads 0x00. Every complemented-window byte reads 0xFF and every plain-window byte reads 0x00.
- R2: After a full sector in generate mode, the parity equals the remainder of D(x)·x^6 modulo g(x). Here D(x) holds the complemented bytes, first byte highest, and g(x) = prod over i=0..5 of (x + alpha^i) in GF(2^10) mod 0x409.
- R3: A sector of all 0xFF data bytes gives 0xFF in all eight complemented-window bytes.
- R4: The packing uses a 60-bit image. Parity symbol k (the coefficient of x^k) sits at image bits [(5-k)*10+9 : (5-k)*10]. Image byte b is bits [8b+7:8b], so symbol 5 fills byte 0 plus the low two bits of byte 1, and symbol 0 fills the top six bits of byte 6 plus the low nibble of byte 7. The complemented window at address 0x10+b returns the inverse of image byte b.
- R5: The plain window at address 0x08+b returns image byte b with bit i moved to bit 7-i.
- R6: The top nibble of complemented-window byte 7 always reads as ones.
- R7: A control write with bit 7 set clears the parity, the byte count and the mismatch flag. While feed (bit 5) is zero, bytes are ignored and the parity holds. A later write with feed set and bit 7 clear resumes the sector where it stopped.
- R8: In check mode the eight bytes after the data are compared with the complemented window; the top nibble of byte 7 is not compared. Bit 7 of the check register (address 0x01) is set from the cycle after the last stored byte when any byte differed. It stays set until a clear.
- R9: Once a sector is complete, further bytes change neither the parity nor the flag.
- R10: The control register (address 0x00) reads back bit 6 (generate) and bit 5 (feed). Bit 7 (clear) reads back as 0.
- R11: In check mode, the stored bytes do not alter the parity windows; they show the parity of the data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address (write and read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_byte | input | 8 | Stream byte |

## Verification
The bench builds the block with the default 512-byte sector. This puts the real sector length within reach: the DATA-to-STORED and DATA-to-DONE transitions at byte 511, the eighth stored byte with its masked nibble, and bytes pushed after DONE. A behavioural model with a byte queue and long division checks the register at the watched address on every clock. Directed checks cover a freeze and resume in mid-sector, a corrupted data byte, a corrupted stored byte, and corruption confined to the unused nibble.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int SYM_W     = 10;
    localparam int NPAR      = 6;
    localparam int PAR_BITS  = NPAR * SYM_W;
    localparam int PAR_BYTES = (PAR_BITS + 7) / 8;
    localparam int PAD_BITS  = PAR_BYTES * 8 - PAR_BITS;
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_CTL = 5'h00;
    localparam logic [ADDR_W-1:0] A_CHK = 5'h01;
    localparam logic [1:0] WIN_REV = 2'b01;
    localparam logic [1:0] WIN_INV = 2'b10;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NPAR:0][SYM_W-1:0] gpoly_t;
    typedef logic [NPAR-1:0][SYM_W-1:0] par_t;
    typedef logic [PAR_BYTES-1:0][7:0] pbytes_t;
    typedef enum logic [1:0] {S_IDLE, S_DATA, S_STORED, S_DONE} phase_e;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc ^= sh;
            sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
        end
        return acc;
    endfunction

    function automatic gpoly_t gen_poly();
        gpoly_t g;
        gpoly_t nxt;
        sym_t   root;
        g    = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            nxt    = '0;
            nxt[0] = gf_mul(g[0], root);
            for (int k = 1; k <= NPAR; k++) begin
                nxt[k] = g[k-1] ^ gf_mul(g[k], root);
            end
            g    = nxt;
            root = gf_mul(root, sym_t'(2));
        end
        return g;
    endfunction
endpackage

// File: rtl/rs_lfsr.sv
module rs_lfsr
    import rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  sym_t din,
    output par_t par
);
    localparam gpoly_t GEN = gen_poly();

    par_t par_q;
    par_t nxt;
    sym_t fb;

    assign fb = din ^ par_q[NPAR-1];

    for (genvar j = 0; j < NPAR; j++) begin : g_tap
        if (j == 0) begin : g_low
            assign nxt[j] = gf_mul(fb, GEN[0]);
        end else begin : g_mid
            assign nxt[j] = par_q[j-1] ^ gf_mul(fb, GEN[j]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   par_q <= '0;
        else if (clr) par_q <= '0;
        else if (adv) par_q <= nxt;
    end

    assign par = par_q;

    // R7
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(par_q));

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_q == '0));
endmodule

// File: rtl/rs_pack.sv
module rs_pack
    import rs_pkg::*;
(
    input  par_t    par,
    output pbytes_t inv_view,
    output pbytes_t rev_view
);
    logic [PAR_BYTES*8-1:0] img;

    assign img[PAR_BITS +: PAD_BITS] = '0;

    for (genvar k = 0; k < NPAR; k++) begin : g_sym
        assign img[(NPAR-1-k)*SYM_W +: SYM_W] = par[k];
    end

    for (genvar b = 0; b < PAR_BYTES; b++) begin : g_byte
        assign inv_view[b] = ~img[8*b +: 8];
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign rev_view[b][i] = img[8*b + 7 - i];
        end
    end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_clr,
    input  logic ctl_gen,
    input  logic ctl_feed,
    input  logic gen_q,
    input  logic in_valid,
    output logic data_take,
    output logic chk_take,
    output logic chk_last,
    output logic [$clog2(PAR_BYTES)-1:0] chk_idx
);
    localparam int TOTAL = SECTOR_BYTES + PAR_BYTES;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int IW    = $clog2(PAR_BYTES);
    localparam logic [CW-1:0] DATA_END  = CW'(SECTOR_BYTES);
    localparam logic [CW-1:0] LAST_DATA = CW'(SECTOR_BYTES - 1);
    localparam logic [CW-1:0] LAST_ALL  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] ALL_END   = CW'(TOTAL);

    phase_e phase_q, phase_d, resume_s;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (cnt_q < DATA_END)     resume_s = S_DATA;
        else if (ctl_gen)         resume_s = S_DONE;
        else if (cnt_q < ALL_END) resume_s = S_STORED;
        else                      resume_s = S_DONE;
    end

    always_comb begin
        data_take = (phase_q == S_DATA)   && in_valid && !ctl_wr;
        chk_take  = (phase_q == S_STORED) && in_valid && !ctl_wr;
        chk_last  = chk_take && (cnt_q == LAST_ALL);
        chk_idx   = IW'(cnt_q - DATA_END);
    end

    always_comb begin
        phase_d = phase_q;
        if (ctl_wr) begin
            if (!ctl_feed)    phase_d = S_IDLE;
            else if (ctl_clr) phase_d = S_DATA;
            else              phase_d = resume_s;
        end else begin
            unique case (phase_q)
                S_IDLE:   phase_d = S_IDLE;
                S_DATA:   if (data_take && cnt_q == LAST_DATA)
                              phase_d = gen_q ? S_DONE : S_STORED;
                S_STORED: if (chk_last) phase_d = S_DONE;
                S_DONE:   phase_d = S_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= S_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (ctl_wr && ctl_clr)  cnt_q <= '0;
        else if (data_take || chk_take) cnt_q <= cnt_q + 1'b1;
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ALL_END);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == S_DONE && !ctl_wr) |=> (phase_q == S_DONE && $stable(cnt_q)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == S_IDLE && !ctl_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rs_page_ecc.sv
module rs_page_ecc
    import rs_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       in_valid,
    input  logic [7:0] in_byte
);
    localparam int IW = $clog2(PAR_BYTES);
    localparam logic [7:0]    LAST_MASK = 8'hFF >> PAD_BITS;
    localparam logic [IW-1:0] LAST_IDX  = IW'(PAR_BYTES - 1);

    logic ctl_wr, ctl_clr, ctl_gen, ctl_feed;
    logic gen_q, feed_q, mism_q, err_q;
    logic data_take, chk_take, chk_last;
    logic [IW-1:0] chk_idx;
    logic [7:0] cmp_mask;
    logic       byte_bad;
    logic       unused_wbits;
    par_t       par;
    pbytes_t    inv_view, rev_view;

    assign ctl_wr       = reg_wr && (reg_addr == A_CTL);
    assign ctl_clr      = reg_wdata[7];
    assign ctl_gen      = reg_wdata[6];
    assign ctl_feed     = reg_wdata[5];
    assign unused_wbits = ^reg_wdata[4:0];

    rs_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_clr  (ctl_clr),
        .ctl_gen  (ctl_gen),
        .ctl_feed (ctl_feed),
        .gen_q    (gen_q),
        .in_valid (in_valid),
        .data_take(data_take),
        .chk_take (chk_take),
        .chk_last (chk_last),
        .chk_idx  (chk_idx)
    );

    rs_lfsr u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctl_wr && ctl_clr),
        .adv  (data_take),
        .din  ({2'b00, ~in_byte}),
        .par  (par)
    );

    rs_pack u_pack (
        .par     (par),
        .inv_view(inv_view),
        .rev_view(rev_view)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q  <= 1'b0;
            feed_q <= 1'b0;
        end else if (ctl_wr) begin
            gen_q  <= ctl_gen;
            feed_q <= ctl_feed;
        end
    end

    assign cmp_mask = (chk_idx == LAST_IDX) ? LAST_MASK : 8'hFF;
    assign byte_bad = |((in_byte ^ inv_view[chk_idx]) & cmp_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (ctl_wr && ctl_clr) begin
            mism_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (chk_take) begin
            mism_q <= mism_q | byte_bad;
            if (chk_last) err_q <= mism_q | byte_bad;
        end
    end

    always_comb begin
        if (reg_addr == A_CTL)          reg_rdata = {1'b0, gen_q, feed_q, 5'b0};
        else if (reg_addr == A_CHK)     reg_rdata = {err_q, 7'b0};
        else if (reg_addr[4:3] == WIN_REV) reg_rdata = rev_view[reg_addr[2:0]];
        else if (reg_addr[4:3] == WIN_INV) reg_rdata = inv_view[reg_addr[2:0]];
        else                            reg_rdata = 8'h00;
    end

    // R8
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(chk_last));

    // R11
    par_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_take |=> $stable(par));
endmodule

// File: tb/rs_page_ecc_bench.sv
module rs_page_ecc_bench;
    localparam int CLK_P = 10;
    localparam int SECT  = 512;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'h01;
    logic [7:0] reg_wdata = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    int gq[7];

    always #(CLK_P/2) clk = ~clk;

    rs_page_ecc #(.SECTOR_BYTES(SECT)) u_rs_page_ecc (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_byte(in_byte)
    );

    function automatic int gm(int a, int b);
        int r = 0;
        int x = a;
        for (int i = 0; i < 10; i++) begin
            if (((b >> i) & 1) != 0) r ^= x;
            x = x << 1;
            if ((x & 'h400) != 0) x ^= 'h409;
        end
        return r;
    endfunction

    function automatic logic [63:0] image_of(bq_t q);
        int a[SECT+6];
        int n = q.size();
        logic [63:0] img = '0;
        for (int i = 0; i < SECT + 6; i++) a[i] = 0;
        for (int i = 0; i < n; i++) a[i] = (~int'(q[i])) & 'hFF;
        for (int i = 0; i < n; i++) begin
            int c = a[i];
            if (c != 0)
                for (int k = 0; k <= 6; k++) a[i+k] ^= gm(c, gq[6-k]);
        end
        for (int k = 0; k < 6; k++) img[(5-k)*10 +: 10] = 10'(a[n+5-k]);
        return img;
    endfunction

    function automatic logic [7:0] revb(logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 'hFF);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    bq_t mq;
    int  m_cnt = 0;
    int  m_ver = 0;
    int  m_ix;
    bit  m_gen = 0, m_feed = 0, m_err = 0, m_acc = 0;
    logic [63:0] m_img = '0;
    logic [7:0]  m_e, m_mk;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_cnt = 0; m_gen = 0; m_feed = 0; m_err = 0; m_acc = 0; m_ver++;
        end else if (reg_wr && reg_addr == 5'h00) begin
            if (reg_wdata[7]) begin
                mq.delete(); m_cnt = 0; m_err = 0; m_acc = 0; m_ver++;
            end
            m_gen  = reg_wdata[6];
            m_feed = reg_wdata[5];
        end else if (in_valid && m_feed && m_cnt < (m_gen ? SECT : SECT + 8)) begin
            if (m_cnt < SECT) begin
                mq.push_back(in_byte);
                m_ver++;
                if (m_cnt == SECT - 1) m_img = image_of(mq);
            end else begin
                m_ix = m_cnt - SECT;
                m_e  = ~m_img[8*m_ix +: 8];
                m_mk = (m_ix == 7) ? 8'h0F : 8'hFF;
                if (((in_byte ^ m_e) & m_mk) != 8'h00) m_acc = 1;
                if (m_ix == 7) m_err = m_acc;
            end
            m_cnt++;
        end
    end

    // every-clock comparison of the watched register
    int c_ver = -1;
    logic [63:0] c_img;
    logic [7:0]  c_e;
    string       c_tag;
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !fin) begin
            if (reg_addr == 5'h00) begin
                c_e = {1'b0, m_gen, m_feed, 5'b0}; c_tag = "R10 ctl";
            end else if (reg_addr == 5'h01) begin
                c_e = {m_err, 7'b0}; c_tag = "R8 chk";
            end else if (reg_addr[4:3] == 2'b01 || reg_addr[4:3] == 2'b10) begin
                if (c_ver != m_ver) begin c_img = image_of(mq); c_ver = m_ver; end
                if (reg_addr[4]) begin c_e = ~c_img[8*reg_addr[2:0] +: 8]; c_tag = "R4 inv"; end
                else begin c_e = revb(c_img[8*reg_addr[2:0] +: 8]); c_tag = "R5 rev"; end
            end else begin
                c_e = 8'h00; c_tag = "R1 unmapped";
            end
            chk(c_tag, reg_rdata, c_e);
        end
    end

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 5'h01;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic push_pat(int first, int n);
        for (int i = first; i < first + n; i++) push(pat(i));
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!fin) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            fin = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [63:0] full_img;
        logic [7:0] saved[8];
        bq_t pq;

        // generator built directly from its roots alpha^0..alpha^5
        begin
            int root = 1;
            for (int k = 0; k < 7; k++) gq[k] = 0;
            gq[0] = 1;
            for (int i = 0; i < 6; i++) begin
                for (int k = 6; k >= 1; k--) gq[k] = gq[k-1] ^ gm(gq[k], root);
                gq[0] = gm(gq[0], root);
                root = gm(root, 2);
            end
        end
        for (int i = 0; i < SECT; i++) pq.push_back(pat(i));
        full_img = image_of(pq);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk("R1 ctl", v, 8'h00);
        rd(5'h01, v); chk("R1 chk", v, 8'h00);
        rd(5'h10, v); chk("R1 inv0", v, 8'hFF);
        rd(5'h17, v); chk("R1 inv7", v, 8'hFF);
        rd(5'h08, v); chk("R1 rev0", v, 8'h00);

        // R10 control readback
        wr_ctl(8'hE0);
        rd(5'h00, v); chk("R10 ctl E0", v, 8'h60);

        // R3 blank sector
        for (int i = 0; i < SECT; i++) push(8'hFF);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R3 blank inv", v, 8'hFF);
            rd(5'(5'h08 + b), v); chk("R5 blank rev", v, 8'h00);
        end

        // R2 R4 R5 R6 pattern sector
        wr_ctl(8'hE0);
        push_pat(0, SECT);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R2 R4 inv", v, ~full_img[8*b +: 8]);
            rd(5'(5'h08 + b), v); chk("R5 rev", v, revb(full_img[8*b +: 8]));
        end
        rd(5'h17, v); chk("R6 nibble", v & 8'hF0, 8'hF0);

        // R9 bytes after completion
        push(8'h00); push(8'h5A); push(8'hC3);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R9 after done", v, ~full_img[8*b +: 8]);
        end

        // R7 freeze and resume
        wr_ctl(8'hE0);
        push_pat(0, 100);
        for (int b = 0; b < 8; b++) rd(5'(5'h10 + b), saved[b]);
        wr_ctl(8'h00);
        rd(5'h00, v); chk("R10 ctl 00", v, 8'h00);
        push(8'h12); push(8'h34); push(8'h56);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R7 frozen", v, saved[b]);
        end
        wr_ctl(8'h60);
        push_pat(100, SECT - 100);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R7 resumed", v, ~full_img[8*b +: 8]);
        end

        // R8 R11 check mode, good stored parity
        wr_ctl(8'hA0);
        push_pat(0, SECT);
        for (int b = 0; b < 8; b++) push(~full_img[8*b +: 8]);
        rd(5'h01, v); chk("R8 good", v, 8'h00);
        for (int b = 0; b < 8; b++) begin
            rd(5'(5'h10 + b), v); chk("R11 inv", v, ~full_img[8*b +: 8]);
        end

        // R8 corrupted stored byte
        wr_ctl(8'hA0);
        push_pat(0, SECT);
        for (int b = 0; b < 7; b++) push(~full_img[8*b +: 8] ^ ((b == 3) ? 8'h01 : 8'h00));
        rd(5'h01, v); chk("R8 before last", v, 8'h00);
        push(~full_img[63:56]);
        rd(5'h01, v); chk("R8 bad stored", v, 8'h80);
        push(8'h00);
        rd(5'h01, v); chk("R8 held", v, 8'h80);
        wr_ctl(8'hA0);
        rd(5'h01, v); chk("R7 clear flag", v, 8'h00);

        // R8 unused nibble not compared
        push_pat(0, SECT);
        for (int b = 0; b < 8; b++) push(~full_img[8*b +: 8] ^ ((b == 7) ? 8'hF0 : 8'h00));
        rd(5'h01, v); chk("R8 nibble masked", v, 8'h00);

        // R8 corrupted data byte
        wr_ctl(8'hA0);
        for (int i = 0; i < SECT; i++) push(pat(i) ^ ((i == 10) ? 8'h40 : 8'h00));
        for (int b = 0; b < 8; b++) push(~full_img[8*b +: 8]);
        rd(5'h01, v); chk("R8 bad data", v, 8'h80);

        @(negedge clk);
        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule